// File: doc/BRIEF.md
# Windowed Register File with Shared Parameter Areas

This block is the integer register file of a processor that gives each procedure its own register window. The datapath sees 32 architectural registers. Indices 0 to 7 are globals shared by all procedures. Indices 8 to 31 are resolved through a current window pointer into a physical bank laid out as a ring of eight windows. Each window owns a parameter area and a local area. Its upper area, the temporaries, is the parameter area of the next window around the ring. A caller can therefore leave arguments in its temporaries and the callee finds them in its parameters without any copy.

Call and return requests move the current window pointer by one. A saved window pointer marks the window most recently pushed out to memory. When a call would run into storage that still belongs to a live frame, the block raises a one-cycle overflow trap. When a return would land on a window that is no longer held in the bank, it raises a one-cycle underflow trap. In both cases the pointer holds until an external engine moves the affected window through a side port and acknowledges. The acknowledge then completes the pending call or return and steps the saved window pointer.

Top module: `regwin_file`

## Requirements
- R1: After a synchronous reset the current window pointer is 0, the saved window pointer is 7, and neither trap output is high.
- R2: Architectural registers 0 to 7 reach the same storage from every window, so a value written to one of them in one window reads back unchanged in any other window.
- R3: A call taken while the current pointer plus one (mod 8) equals the saved pointer raises overflow for exactly one cycle, starting in the cycle after the request edge, and leaves the current pointer unchanged. Overflow and underflow are never high together.
- R4: Architectural registers 24 to 31 of window w and registers 8 to 15 of window w+1 (mod 8) are the same storage, offset for offset.
- R5: Architectural registers 16 to 23 are private to each window. A write in one window does not alter the same index in a neighbouring window.
- R6: Reads on both ports are combinational and return the value stored before the current edge. A write takes effect at the clock edge.
- R7: A call that does not trap adds one to the current pointer, and a return that does not trap subtracts one. Both wrap modulo 8, and the pointer moves by at most one per cycle.
- R8: A return taken while the current pointer minus one (mod 8) equals the saved pointer raises underflow for exactly one cycle, starting in the cycle after the request edge, and leaves the current pointer unchanged.
- R9: An acknowledge while an overflow is pending adds one to both pointers. An acknowledge while an underflow is pending subtracts one from both. The two pointers are never equal.
- R10: While a trap is pending, call and return requests are ignored. An acknowledge with no pending trap changes neither pointer.
- R11: The side port addresses window w, offset 0 to 7 as that window's parameters and offset 8 to 15 as its locals. Its read is combinational. A side write to the same cell as a datapath write in the same cycle wins.
- R12: When call and return are requested in the same cycle, the call is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Architectural index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 5 | Architectural index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Datapath write enable |
| wr_idx | input | 5 | Architectural index for the write |
| wr_data | input | 32 | Write data |
| call_req | input | 1 | Procedure call: move to the next window |
| ret_req | input | 1 | Procedure return: move to the previous window |
| trap_ack | input | 1 | Handler finished moving the window |
| ovf_trap | output | 1 | One-cycle window overflow pulse |
| unf_trap | output | 1 | One-cycle window underflow pulse |
| cwp | output | 3 | Current window pointer |
| swp | output | 3 | Saved window pointer |
| side_win | input | 3 | Window addressed by the side port |
| side_off | input | 4 | Offset in that window (0-7 parameters, 8-15 locals) |
| side_we | input | 1 | Side port write enable |
| side_wdata | input | 32 | Side port write data |
| side_rdata | output | 32 | Side port read data |

## Verification
Read data on both ports and on the side port is combinational. The bench therefore sets an index and samples one time step later within the same cycle, before any edge. Written values, pointer moves and trap pulses appear one register stage after the edge that samples the request. Each task drives its inputs just after a rising edge, waits for the next edge, and samples one time step after it. Trap pulses are checked high in that first cycle and low in the next. Pointer holds are checked in the same cycles.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int GLOB_N = 8;           // shared registers at the bottom of the bank
    localparam int AREA_N = 8;           // registers per window area
    localparam int AIDX_W = 5;           // architectural index width
    localparam int WIN_OWN = 2 * AREA_N; // parameters plus locals held by a window

    typedef enum logic [1:0] {
        AR_GLOB = 2'd0,
        AR_PARM = 2'd1,
        AR_LOCL = 2'd2,
        AR_TEMP = 2'd3
    } area_e;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_SPILL = 2'd1,
        PS_FILL  = 2'd2
    } ptr_state_e;

    function automatic area_e area_of(input logic [AIDX_W-1:0] idx);
        return area_e'(idx[4:3]);
    endfunction

    function automatic int bank_base(input int win);
        return GLOB_N + win * WIN_OWN;
    endfunction
endpackage

// File: rtl/regwin_map.sv
module regwin_map
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WW   = 3,
    parameter int PW   = 8
) (
    input  logic [AIDX_W-1:0] arch_idx,
    input  logic [WW-1:0]     cur_win,
    output logic [PW-1:0]     phys_idx
);
    area_e       area;
    logic [WW-1:0] win;
    int          slot;

    always_comb begin
        area = area_of(arch_idx);
        // temporaries live in the parameter area of the next window
        win  = (area == AR_TEMP) ? cur_win + WW'(1) : cur_win;
        slot = int'(arch_idx[2:0]);
        unique case (area)
            AR_GLOB: phys_idx = PW'(int'(arch_idx));
            AR_LOCL: phys_idx = PW'(bank_base(int'(win)) + AREA_N + slot);
            default: phys_idx = PW'(bank_base(int'(win)) + slot);
        endcase
    end
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
    parameter int DEPTH = 136,
    parameter int DW    = 32,
    parameter int PW    = 8,
    parameter int NRD   = 3
) (
    input  logic          clk,
    input  logic [PW-1:0] rd_idx  [NRD],
    output logic [DW-1:0] rd_data [NRD],
    input  logic          dp_we,
    input  logic [PW-1:0] dp_idx,
    input  logic [DW-1:0] dp_data,
    input  logic          sp_we,
    input  logic [PW-1:0] sp_idx,
    input  logic [DW-1:0] sp_data
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = mem[rd_idx[g]];
    end

    // side port write comes last so it wins on a shared cell
    always_ff @(posedge clk) begin
        if (dp_we) mem[dp_idx] <= dp_data;
        if (sp_we) mem[sp_idx] <= sp_data;
    end
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic          trap_ack,
    output logic [WW-1:0] cwp,
    output logic [WW-1:0] swp,
    output logic          ovf_trap,
    output logic          unf_trap,
    output logic          busy
);
    ptr_state_e    state;
    logic [WW-1:0] next_up, next_dn;

    assign next_up = cwp + WW'(1);
    assign next_dn = cwp - WW'(1);
    assign busy    = (state != PS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_IDLE;
            cwp      <= '0;
            swp      <= WW'(NWIN - 1);
            ovf_trap <= 1'b0;
            unf_trap <= 1'b0;
        end else begin
            ovf_trap <= 1'b0;
            unf_trap <= 1'b0;
            unique case (state)
                PS_IDLE: begin
                    if (call_req) begin
                        if (next_up == swp) begin
                            ovf_trap <= 1'b1;
                            state    <= PS_SPILL;
                        end else begin
                            cwp <= next_up;
                        end
                    end else if (ret_req) begin
                        if (next_dn == swp) begin
                            unf_trap <= 1'b1;
                            state    <= PS_FILL;
                        end else begin
                            cwp <= next_dn;
                        end
                    end
                end
                PS_SPILL: if (trap_ack) begin
                    swp   <= swp + WW'(1);
                    cwp   <= next_up;
                    state <= PS_IDLE;
                end
                PS_FILL: if (trap_ack) begin
                    swp   <= swp - WW'(1);
                    cwp   <= next_dn;
                    state <= PS_IDLE;
                end
                default: state <= PS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    parameter int WW   = $clog2(NWIN),
    parameter int SOW  = $clog2(WIN_OWN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AIDX_W-1:0] rd_a_idx,
    output logic [DW-1:0]     rd_a_data,
    input  logic [AIDX_W-1:0] rd_b_idx,
    output logic [DW-1:0]     rd_b_data,
    input  logic              wr_en,
    input  logic [AIDX_W-1:0] wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic              trap_ack,
    output logic              ovf_trap,
    output logic              unf_trap,
    output logic [WW-1:0]     cwp,
    output logic [WW-1:0]     swp,
    input  logic [WW-1:0]     side_win,
    input  logic [SOW-1:0]    side_off,
    input  logic              side_we,
    input  logic [DW-1:0]     side_wdata,
    output logic [DW-1:0]     side_rdata
);
    localparam int DEPTH = GLOB_N + NWIN * WIN_OWN;
    localparam int PW    = $clog2(DEPTH);
    localparam int NMAP  = 3;   // two read ports and the write port

    logic [AIDX_W-1:0] arch_idx [NMAP];
    logic [PW-1:0]     phys_idx [NMAP];
    logic [PW-1:0]     bank_rd  [3];
    logic [DW-1:0]     bank_q   [3];
    logic [PW-1:0]     side_phys;
    logic              trap_busy;

    assign arch_idx[0] = rd_a_idx;
    assign arch_idx[1] = rd_b_idx;
    assign arch_idx[2] = wr_idx;

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        regwin_map #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_map (
            .arch_idx (arch_idx[g]),
            .cur_win  (cwp),
            .phys_idx (phys_idx[g])
        );
    end

    assign side_phys  = PW'(bank_base(int'(side_win)) + int'(side_off));
    assign bank_rd[0] = phys_idx[0];
    assign bank_rd[1] = phys_idx[1];
    assign bank_rd[2] = side_phys;
    assign rd_a_data  = bank_q[0];
    assign rd_b_data  = bank_q[1];
    assign side_rdata = bank_q[2];

    regwin_bank #(.DEPTH(DEPTH), .DW(DW), .PW(PW), .NRD(3)) u_bank (
        .clk     (clk),
        .rd_idx  (bank_rd),
        .rd_data (bank_q),
        .dp_we   (wr_en),
        .dp_idx  (phys_idx[2]),
        .dp_data (wr_data),
        .sp_we   (side_we),
        .sp_idx  (side_phys),
        .sp_data (side_wdata)
    );

    regwin_ptr #(.NWIN(NWIN), .WW(WW)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .call_req (call_req),
        .ret_req  (ret_req),
        .trap_ack (trap_ack),
        .cwp      (cwp),
        .swp      (swp),
        .ovf_trap (ovf_trap),
        .unf_trap (unf_trap),
        .busy     (trap_busy)
    );
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
    parameter int WW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          trap_ack,
    input logic          ovf_trap,
    input logic          unf_trap,
    input logic          busy,
    input logic [WW-1:0] cwp,
    input logic [WW-1:0] swp
);
    assert_ovf_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_trap |=> !ovf_trap);
    assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_trap |-> cwp == $past(cwp));
    assert_no_both_R3: assert property (@(posedge clk) disable iff (rst)
        !(ovf_trap && unf_trap));
    assert_unf_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        unf_trap |=> !unf_trap);
    assert_unf_hold_R8: assert property (@(posedge clk) disable iff (rst)
        unf_trap |-> cwp == $past(cwp));
    assert_one_step_R7: assert property (@(posedge clk) disable iff (rst)
        (cwp == $past(cwp)) || (cwp == WW'($past(cwp) + 1'b1))
        || (cwp == WW'($past(cwp) - 1'b1)));
    assert_swp_on_ack_R9: assert property (@(posedge clk) disable iff (rst)
        !trap_ack |=> $stable(swp));
    assert_ptr_apart_R9: assert property (@(posedge clk) disable iff (rst)
        cwp != swp);
    assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !trap_ack) |=> $stable(cwp));
endmodule

bind regwin_file regwin_chk #(.WW(WW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trap_ack (trap_ack),
    .ovf_trap (ovf_trap),
    .unf_trap (unf_trap),
    .busy     (trap_busy),
    .cwp      (cwp),
    .swp      (swp)
);

// File: tb/regwin_file_tb_top.sv
module regwin_file_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, call_req = 1'b0, ret_req = 1'b0, trap_ack = 1'b0;
    logic        ovf_trap, unf_trap;
    logic [2:0]  cwp, swp, side_win = '0;
    logic [3:0]  side_off = '0;
    logic        side_we = 1'b0;
    logic [31:0] side_wdata = '0, side_rdata;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    regwin_file dut_i (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .call_req(call_req), .ret_req(ret_req), .trap_ack(trap_ack),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap), .cwp(cwp), .swp(swp),
        .side_win(side_win), .side_off(side_off), .side_we(side_we),
        .side_wdata(side_wdata), .side_rdata(side_rdata)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] d);
        rd_b_idx = idx;
        #1;
        d = rd_b_data;
    endtask

    task automatic do_call();
        call_req = 1'b1; tick(); call_req = 1'b0;
    endtask

    task automatic do_ret();
        ret_req = 1'b1; tick(); ret_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cwp", 32'(cwp), 0);
        chk("R1 swp", 32'(swp), 7);
        chk("R1 ovf", 32'(ovf_trap), 0);
        chk("R1 unf", 32'(unf_trap), 0);
    endtask

    task automatic t_global();
        logic [31:0] v;
        wr(5'd3, 32'hA0A0_0003);
        do_call();
        rd(5'd3, v); chk("R2 global seen from window 1", v, 32'hA0A0_0003);
        wr(5'd5, 32'hB0B0_0005);
        do_ret();
        rd(5'd5, v); chk("R2 global seen from window 0", v, 32'hB0B0_0005);
    endtask

    task automatic t_overlap();
        logic [31:0] v;
        wr(5'd26, 32'hC0C0_001A);
        do_call();
        rd(5'd10, v); chk("R4 caller temp is callee param", v, 32'hC0C0_001A);
        wr(5'd12, 32'hD0D0_000C);
        do_ret();
        rd(5'd28, v); chk("R4 callee param is caller temp", v, 32'hD0D0_000C);
    endtask

    task automatic t_local();
        logic [31:0] v;
        wr(5'd16, 32'hE0E0_0010);
        do_call();
        wr(5'd16, 32'hF0F0_0010);
        rd(5'd16, v); chk("R5 callee local", v, 32'hF0F0_0010);
        do_ret();
        rd(5'd16, v); chk("R5 caller local kept", v, 32'hE0E0_0010);
    endtask

    task automatic t_rw_timing();
        wr(5'd20, 32'h1111_2222);
        wr_en = 1'b1; wr_idx = 5'd20; wr_data = 32'h3333_4444; rd_a_idx = 5'd20;
        #1;
        chk("R6 read before edge is old", rd_a_data, 32'h1111_2222);
        tick();
        wr_en = 1'b0;
        chk("R6 read after edge is new", rd_a_data, 32'h3333_4444);
    endtask

    task automatic t_overflow();
        for (int i = 1; i <= 6; i++) begin
            do_call();
            chk("R7 call step", 32'(cwp), 32'(i));
        end
        call_req = 1'b1; tick(); call_req = 1'b0;
        chk("R3 ovf raised", 32'(ovf_trap), 1);
        chk("R3 cwp held", 32'(cwp), 6);
        ret_req = 1'b1; tick(); ret_req = 1'b0;
        chk("R3 ovf one cycle", 32'(ovf_trap), 0);
        chk("R10 return ignored while pending", 32'(cwp), 6);
        trap_ack = 1'b1; tick(); trap_ack = 1'b0;
        chk("R9 ovf ack cwp", 32'(cwp), 7);
        chk("R9 ovf ack swp", 32'(swp), 0);
        call_req = 1'b1; tick(); call_req = 1'b0;
        chk("R3 second ovf", 32'(ovf_trap), 1);
        trap_ack = 1'b1; tick(); trap_ack = 1'b0;
        chk("R7 cwp wraps to 0", 32'(cwp), 0);
        chk("R9 swp 1", 32'(swp), 1);
    endtask

    task automatic t_underflow();
        for (int i = 0; i < 6; i++) begin
            do_ret();
            chk("R7 return step", 32'(cwp), 32'((7 - i) % 8));
        end
        ret_req = 1'b1; tick(); ret_req = 1'b0;
        chk("R8 unf raised", 32'(unf_trap), 1);
        chk("R8 cwp held", 32'(cwp), 2);
        trap_ack = 1'b1; tick(); trap_ack = 1'b0;
        chk("R8 unf one cycle", 32'(unf_trap), 0);
        chk("R9 unf ack cwp", 32'(cwp), 1);
        chk("R9 unf ack swp", 32'(swp), 0);
        trap_ack = 1'b1; tick(); trap_ack = 1'b0;
        chk("R10 idle ack swp", 32'(swp), 0);
        chk("R10 idle ack cwp", 32'(cwp), 1);
    endtask

    task automatic t_side();
        logic [31:0] v;
        wr(5'd17, 32'h5151_0011);
        side_win = 3'd1; side_off = 4'd9;
        #1;
        chk("R11 side reads local", side_rdata, 32'h5151_0011);
        side_off = 4'd2; side_we = 1'b1; side_wdata = 32'h6262_0002;
        wr_en = 1'b1; wr_idx = 5'd10; wr_data = 32'h7373_0002;
        tick();
        side_we = 1'b0; wr_en = 1'b0;
        rd(5'd10, v); chk("R11 side write wins", v, 32'h6262_0002);
    endtask

    task automatic t_both();
        call_req = 1'b1; ret_req = 1'b1; tick();
        call_req = 1'b0; ret_req = 1'b0;
        chk("R12 call wins", 32'(cwp), 2);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_global();
        t_overlap();
        t_local();
        t_rw_timing();
        t_overflow();
        t_underflow();
        t_side();
        t_both();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule